// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a small synchronous static RAM. Its word is 36 bits wide and is split into four 9-bit byte lanes. All commands are sampled on the rising clock edge: chip select, read/write, burst advance, address and per-lane write strobes. A read command puts the addressed word on the output in the same cycle that follows the sampling edge. The output comes straight from the array, with no output register stage.

Writes use a late-data scheme. The write command and address are sampled on one edge, and the write data is sampled on the next edge, where the array is updated. A read can therefore follow a write in the next cycle, and a write can follow a read, with no idle cycle on the data bus in either direction.

A 2-bit burst counter supplies the two low address bits. It moves one step on every cycle in which the advance input is high. A static order input selects linear or interleaved stepping. Output enable and the order input act without the clock. The output is modelled as a data bus plus a valid flag that stands in for high impedance.

Top module: `zbt_ft_sram`

## Requirements
- R1: While reset is high, and after reset until the first command, `rvalid_o` is 0 and `rdata_o` is all zeros.
- R2: A read command sampled on an edge (`cs_i`=1, `adv_i`=0, `we_i`=0) drives the word at `addr_i` onto `rdata_o`, with `rvalid_o`=1, in the cycle right after that edge.
- R3: A write command (`cs_i`=1, `adv_i`=0, `we_i`=1) takes its data from `wdata_i` on the following edge. Lane i (bits 9i+8..9i) is updated only when bit i of `bwe_i` was 1 at the command edge. `rvalid_o` is 0 in a write cycle.
- R4: A read of an address issued on the edge that takes in the write data for that same address returns the new data in the next cycle, with no idle cycle between them.
- R5: A write command may directly follow a read, and that read's data is intact. The written data is then readable right away.
- R6: With `linear_i`=1, beat n of a burst that starts at low address bits s uses low bits (s+n) mod 4. The upper address bits stay fixed.
- R7: With `linear_i`=0, beat n of a burst uses low bits s XOR n.
- R8: When `adv_i`=1, the values of `cs_i`, `we_i` and `addr_i` are ignored and the previous operation continues. An advance after a deselect keeps the block deselected.
- R9: `oe_i`=0 forces `rvalid_o` to 0 and `rdata_o` to zero without waiting for a clock edge. Raising `oe_i` restores the read data in the same cycle.
- R10: A deselect (`cs_i`=0, `adv_i`=0) sampled on an edge drops `rvalid_o` in the very next cycle. A write whose data arrives on that deselect edge is still stored.
- R11: Changing `linear_i` in the middle of a burst cycle changes the addressed word within that cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select for a new command |
| we_i | input | 1 | 1 = write command, 0 = read command |
| adv_i | input | 1 | Advance the burst and continue the current operation |
| addr_i | input | AW (4) | Word address of a new command |
| wdata_i | input | 36 | Write data, one cycle after its command |
| bwe_i | input | 4 | Per-lane write strobes, sampled with the command |
| oe_i | input | 1 | Asynchronous output enable |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata_o | output | 36 | Flow-through read data, zero when not valid |
| rvalid_o | output | 1 | Output driven (stands in for not high impedance) |

## Verification
A full-depth sweep writes every word back to back and then reads every word back to back. This separates address decode faults from faults in write-data timing, because each word holds a distinct value.

Every one of the 16 byte-strobe patterns is applied over a known background word, which exposes any lane that is swapped or stuck. Bursts from all four start offsets are run in both orders, with junk on the address and command inputs during advance beats. These tell linear stepping from interleaved stepping, and show whether advance really ignores the other inputs.

Short read-write-read sequences on a single address, and toggling of the asynchronous enable and order inputs in mid-cycle, check the turnaround and the paths that bypass the clock.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;

  // Low address bits for burst beat 'step' starting at offset 'start'.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       linear);
    return linear ? 2'(start + step) : (start ^ step);
  endfunction

endpackage

// File: rtl/zbt_ctrl_reg.sv
`timescale 1ns/1ps
module zbt_ctrl_reg
  import zbt_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic             adv_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bwe_i,
  output logic             active_o,
  output op_e              op_o,
  output logic [AW-1:0]    base_o,
  output logic [1:0]       step_o,
  output logic [LANES-1:0] bwe_o
);

  logic             active_q;
  op_e              op_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       step_q;
  logic [LANES-1:0] bwe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      op_q     <= OP_READ;
      base_q   <= '0;
      step_q   <= '0;
      bwe_q    <= '0;
    end else if (adv_i) begin
      // continue the current operation; a deselected state stays deselected
      if (active_q) step_q <= step_q + 2'd1;
      bwe_q <= bwe_i;
    end else if (cs_i) begin
      active_q <= 1'b1;
      op_q     <= we_i ? OP_WRITE : OP_READ;
      base_q   <= addr_i;
      step_q   <= '0;
      bwe_q    <= bwe_i;
    end else begin
      active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign op_o     = op_q;
  assign base_o   = base_q;
  assign step_o   = step_q;
  assign bwe_o    = bwe_q;

  assert_deselect_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    (!cs_i && !adv_i) |=> !active_q);

  assert_new_cmd_starts_burst_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_i && !adv_i) |=> (active_q && step_q == 2'd0 && base_q == $past(addr_i)));

  assert_adv_keeps_op_R8: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> (op_q == $past(op_q) && base_q == $past(base_q) && active_q == $past(active_q)));

endmodule

// File: rtl/zbt_addr_gen.sv
`timescale 1ns/1ps
module zbt_addr_gen
  import zbt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    step_i,
  input  logic          linear_i,
  output logic [AW-1:0] addr_o
);

  logic [1:0] low;
  assign low = burst_low(base_i[1:0], step_i, linear_i);

  generate
    if (AW > 2) begin : g_wide
      assign addr_o = {base_i[AW-1:2], low};
    end else begin : g_narrow
      assign addr_o = low;
    end
  endgenerate

endmodule

// File: rtl/zbt_lane_array.sv
`timescale 1ns/1ps
module zbt_lane_array #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      end

      assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
    end
  endgenerate

endmodule

// File: rtl/zbt_ft_sram.sv
`timescale 1ns/1ps
module zbt_ft_sram
  import zbt_pkg::*;
#(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_i,
  input  logic                    we_i,
  input  logic                    adv_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [LANES-1:0]        bwe_i,
  input  logic                    oe_i,
  input  logic                    linear_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);

  localparam int DW = LANES * LANE_W;

  logic             active;
  op_e              op;
  logic [AW-1:0]    base;
  logic [1:0]       step;
  logic [LANES-1:0] bwe_q;
  logic [AW-1:0]    cur_addr;
  logic [LANES-1:0] lane_we;
  logic [DW-1:0]    array_q;
  logic             read_sel;

  zbt_ctrl_reg #(.AW(AW), .LANES(LANES)) ctrl_i (
    .clk(clk), .rst(rst), .cs_i(cs_i), .we_i(we_i), .adv_i(adv_i),
    .addr_i(addr_i), .bwe_i(bwe_i),
    .active_o(active), .op_o(op), .base_o(base), .step_o(step), .bwe_o(bwe_q)
  );

  zbt_addr_gen #(.AW(AW)) agen_i (
    .base_i(base), .step_i(step), .linear_i(linear_i), .addr_o(cur_addr)
  );

  // The command register doubles as the one-deep pending-write slot:
  // data arrives on the edge after the command and commits on that edge.
  assign lane_we = (active && op == OP_WRITE) ? bwe_q : '0;

  zbt_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .we_i(lane_we), .addr_i(cur_addr), .wdata_i(wdata_i), .rdata_o(array_q)
  );

  assign read_sel = active && (op == OP_READ);
  assign rvalid_o = read_sel && oe_i;
  assign rdata_o  = rvalid_o ? array_q : '0;

  assert_oe_gates_output_R9: assert property (@(posedge clk) disable iff (rst)
    !oe_i |-> (!rvalid_o && rdata_o == '0));

  assert_no_drive_in_write_R3: assert property (@(posedge clk) disable iff (rst)
    (lane_we != '0) |-> !rvalid_o);

  assert_read_after_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_i && !adv_i && !we_i && oe_i) |=> (rvalid_o || !oe_i));

endmodule

// File: tb/zbt_ft_sram_tb.sv
`timescale 1ns/1ps
module zbt_ft_sram_tb_top;

  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_i = 1'b0, we_i = 1'b0, adv_i = 1'b0, oe_i = 1'b1, linear_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [3:0] bwe_i = '0;
  logic [DW-1:0] rdata_o;
  logic rvalid_o;

  int n_checks = 0;
  int n_err = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #5 clk = ~clk;

  zbt_ft_sram #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cs_i(cs_i), .we_i(we_i), .adv_i(adv_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .bwe_i(bwe_i), .oe_i(oe_i),
    .linear_i(linear_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [63:0] t;
    t = 64'(a) * 64'd2654435761 + 64'(salt) * 64'd40503 + 64'd12345;
    return t[35:0] ^ {t[63:36], 8'h5A};
  endfunction

  function automatic logic [1:0] order_low(input int s, input int n, input bit lin);
    return lin ? 2'((s + n) % 4) : 2'(s ^ n);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, pass the rising edge, return 2 ns after it.
  task automatic cyc(input logic cs, input logic we, input logic adv,
                     input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [3:0] be);
    @(negedge clk);
    cs_i = cs; we_i = we; adv_i = adv; addr_i = a; wdata_i = wd; bwe_i = be;
    @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] d, b, nw, exp;
    // R1: reset state
    repeat (3) begin @(posedge clk); #2; end
    check("R1 rvalid in reset", {35'd0, rvalid_o}, '0);
    check("R1 rdata in reset", rdata_o, '0);
    @(negedge clk); rst = 1'b0;
    cyc(0, 0, 0, 0, 0, 0);
    check("R1 rvalid after reset", {35'd0, rvalid_o}, '0);

    // R3/R4: back-to-back full-word write sweep, then read sweep
    cyc(1, 1, 0, 0, 0, 4'hF);
    check("R3 no drive in write", {35'd0, rvalid_o}, '0);
    for (int a = 1; a < DEPTH; a++) begin
      cyc(1, 1, 0, AW'(a), pat(a - 1, 1), 4'hF);
      ref_mem[a - 1] = pat(a - 1, 1);
    end
    cyc(1, 0, 0, 0, pat(DEPTH - 1, 1), 4'h0);
    ref_mem[DEPTH - 1] = pat(DEPTH - 1, 1);
    check("R4 write->read rvalid", {35'd0, rvalid_o}, 36'd1);
    check("R2 read word 0", rdata_o, ref_mem[0]);
    for (int a = 1; a < DEPTH; a++) begin
      cyc(1, 0, 0, AW'(a), 0, 0);
      check("R2 read sweep", rdata_o, ref_mem[a]);
    end

    // R4: write then immediate read of the same address
    d = pat(5, 2);
    cyc(1, 1, 0, 5, 0, 4'hF);
    cyc(1, 0, 0, 5, d, 0);
    ref_mem[5] = d;
    check("R4 same-address forward", rdata_o, d);

    // R5: read -> write -> read on one address
    cyc(1, 0, 0, 7, 0, 0);
    check("R5 read before write", rdata_o, ref_mem[7]);
    d = pat(7, 3);
    cyc(1, 1, 0, 7, 0, 4'hF);
    check("R5 write cycle no drive", {35'd0, rvalid_o}, '0);
    cyc(1, 0, 0, 7, d, 0);
    ref_mem[7] = d;
    check("R5 read after write", rdata_o, d);

    // R3: every byte-strobe pattern over a background word
    for (int be = 0; be < 16; be++) begin
      b = pat(9, 100 + be);
      nw = pat(9, 200 + be);
      cyc(1, 1, 0, 9, 0, 4'hF);
      cyc(1, 1, 0, 9, b, 4'(be));
      cyc(1, 0, 0, 9, nw, 0);
      for (int l = 0; l < 4; l++)
        exp[l*9 +: 9] = be[l] ? nw[l*9 +: 9] : b[l*9 +: 9];
      ref_mem[9] = exp;
      check("R3 byte lanes", rdata_o, exp);
    end

    // R6/R7/R8: bursts from every start in both orders, junk inputs on adv beats
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); linear_i = lin[0];
        cyc(1, 1, 0, AW'(8 + s), 0, 4'hF);
        for (int n = 1; n < 4; n++) begin
          d = pat(8 + order_low(s, n - 1, lin[0]), 300 + lin * 16 + s * 4 + n);
          cyc(0, 0, 1, AW'(15 - n), d, 4'hF);
          ref_mem[8 + order_low(s, n - 1, lin[0])] = d;
        end
        d = pat(8 + order_low(s, 3, lin[0]), 300 + lin * 16 + s * 4 + 4);
        cyc(0, 0, 0, 0, d, 0);
        ref_mem[8 + order_low(s, 3, lin[0])] = d;
        check("R10 deselect after write", {35'd0, rvalid_o}, '0);
        cyc(1, 0, 0, AW'(8 + s), 0, 0);
        check(lin ? "R6 linear beat0" : "R7 interleaved beat0", rdata_o, ref_mem[8 + s]);
        for (int n = 1; n < 4; n++) begin
          cyc(1, 1, 1, AW'(n), 36'hF_FFFF_FFFF, 4'hF);
          check("R8 adv ignores we", {35'd0, rvalid_o}, 36'd1);
          check(lin ? "R6 linear beat" : "R7 interleaved beat", rdata_o,
                ref_mem[8 + order_low(s, n, lin[0])]);
        end
      end
    end

    // R11: order select changes the addressed word within the cycle
    cyc(1, 0, 0, 9, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    @(negedge clk); linear_i = 1'b1; #1;
    check("R11 linear mid-cycle", rdata_o, ref_mem[10]);
    linear_i = 1'b0; #1;
    check("R11 interleaved mid-cycle", rdata_o, ref_mem[8]);

    // R9: output enable acts within the cycle
    cyc(1, 0, 0, 3, 0, 0);
    @(negedge clk); oe_i = 1'b0; #1;
    check("R9 oe low rvalid", {35'd0, rvalid_o}, '0);
    check("R9 oe low rdata", rdata_o, '0);
    oe_i = 1'b1; #1;
    check("R9 oe high restores", rdata_o, ref_mem[3]);

    // R10 / R8: single-cycle deselect, advance while deselected
    cyc(1, 0, 0, 3, 0, 0);
    check("R10 read before deselect", {35'd0, rvalid_o}, 36'd1);
    cyc(0, 0, 0, 3, 0, 0);
    check("R10 deselect next cycle", {35'd0, rvalid_o}, '0);
    cyc(1, 0, 1, 3, 0, 0);
    check("R8 adv stays deselected", {35'd0, rvalid_o}, '0);
    check("R8 adv deselected rdata", rdata_o, '0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule